// File: doc/BRIEF.md
# Receive Frame Status Generator

This block observes an Ethernet frame while it is received, one byte per valid cycle, and condenses it into a single 16-bit status word. While the bytes stream past, it compares the destination address with the programmed station address, detects broadcast and group destinations, counts the bytes with a saturating counter, and runs a CRC-32 over everything received, including the frame check sequence.

A frame is a `frm_start` pulse, then the bytes, each qualified by `byte_vld`, then a `frm_end` pulse. The per-frame error inputs and the speed mode are sampled on the `frm_end` cycle. One clock later the status word is presented with `stat_vld`. The word stays frozen until the next `frm_start`, so a downstream writer can collect it at any point in that window.

Top module: `rx_status_gen`

## Requirements
- R1: Status bit layout: 15 group (multicast) destination, 14 station address match, 13 broadcast, 5 symbol error, 4 short frame, 3 oversize frame, 2 CRC error, 1 alignment error, 0 frame good. Bits 12 down to 6 always read 0.
- R2: Bit 14 is set when all six destination bytes were received and equal `station_id`. The first received byte is compared with `station_id[7:0]`, and byte i with `station_id[8i+7:8i]`.
- R3: Bit 13 is set when all six destination bytes are 0xFF.
- R4: Bit 15 is set when bit 0 of the first destination byte is 1, all six destination bytes were received, and the destination is not all ones. Bits 15 and 13 are never both set.
- R5: Bit 4 is set when the total byte count, including the frame check sequence, is below 64.
- R6: Bit 3 is set when the byte count exceeds 4096. The counter saturates and does not wrap, so a frame of 8195 bytes still reports oversize and not short.
- R7: Bit 2 is set unless the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, no final inversion) over every received byte, FCS included, ends at the residue 0xDEBB20E3.
- R8: Bit 5 equals `sym_err` AND `speed100`, both sampled at `frm_end`. At 10 Mb/s (`speed100`=0) a symbol error has no effect.
- R9: Bit 1 equals `align_err` sampled at `frm_end`.
- R10: Bit 0 is 1 exactly when bits 5 down to 1 are all 0.
- R11: `stat_vld` rises on the cycle after `frm_end`. It stays high with `stat_word` unchanged until a `frm_start`, and it is low on the cycle after `frm_start`. Cycles without `byte_vld` add no byte to the count, the address compare or the CRC.
- R12: After reset, `stat_word` is 0 and `stat_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start-of-frame pulse, in a cycle that carries no byte |
| byte_vld | input | 1 | `byte_data` carries a frame byte |
| byte_data | input | 8 | Received byte |
| frm_end | input | 1 | End-of-frame pulse, in a cycle that carries no byte |
| sym_err | input | 1 | Invalid symbol seen in this frame, sampled at `frm_end` |
| align_err | input | 1 | Alignment error in this frame, sampled at `frm_end` |
| speed100 | input | 1 | 1 when the link runs at 100 Mb/s |
| station_id | input | 48 | Programmed station address, first byte in bits 7:0 |
| stat_word | output | 16 | Receive status word |
| stat_vld | output | 1 | `stat_word` belongs to the last completed frame |

## Verification
The sweep covers every frame length from 0 to 70 bytes, rotating through five destination types: the station address, broadcast, a group address, a foreign unicast, and an address that differs from the station address only in its last byte. This separates the short-frame edge at 64 and the six-byte minimum for address classes from errors in the compare itself. Frames of 4095 to 4098 bytes locate the oversize edge. A frame of 8195 bytes distinguishes a saturating counter from one that wraps into the short range. Corrupted check sequences, symbol errors at both speeds, alignment errors and idle gaps between bytes test the CRC, the speed gating and the byte qualification.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int unsigned STAT_W   = 16;
  localparam int unsigned B_MCAST  = 15;
  localparam int unsigned B_PAM    = 14;
  localparam int unsigned B_BCAST  = 13;
  localparam int unsigned B_SYM    = 5;
  localparam int unsigned B_SHORT  = 4;
  localparam int unsigned B_LONG   = 3;
  localparam int unsigned B_CRC    = 2;
  localparam int unsigned B_ALIGN  = 1;
  localparam int unsigned B_GOOD   = 0;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  // one byte of the LSB-first CRC-32 update
  function automatic logic [31:0] crc_byte_step(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxs_len_count.sv
module rxs_len_count #(
  parameter int unsigned MAX_LEN = 4096,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] cnt
);

  localparam logic [LEN_W-1:0] SAT = LEN_W'(MAX_LEN + 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rxs_addr_class.sv
module rxs_addr_class #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned LEN_W      = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_data,
  input  logic [LEN_W-1:0]        byte_idx,
  input  logic [8*ADDR_BYTES-1:0] station_id,
  output logic                    pam,
  output logic                    bcast,
  output logic                    mcast
);

  logic [ADDR_BYTES-1:0] own_hit;
  logic [ADDR_BYTES-1:0] ones_hit;
  logic                  grp_bit;
  logic                  dst_done;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        own_hit[i]  <= 1'b0;
        ones_hit[i] <= 1'b0;
      end else if (byte_vld && byte_idx == LEN_W'(i)) begin
        own_hit[i]  <= (byte_data == station_id[8*i +: 8]);
        ones_hit[i] <= (byte_data == 8'hFF);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      grp_bit  <= 1'b0;
      dst_done <= 1'b0;
    end else if (byte_vld) begin
      if (byte_idx == '0) grp_bit <= byte_data[0];
      if (byte_idx == LEN_W'(ADDR_BYTES - 1)) dst_done <= 1'b1;
    end
  end

  assign pam   = &own_hit;
  assign bcast = &ones_hit;
  assign mcast = grp_bit & dst_done & ~bcast;

endmodule

// File: rtl/rxs_crc32.sv
module rxs_crc32 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  output logic       crc_ok
);
  import rxs_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= 32'hFFFF_FFFF;
    end else if (byte_vld) begin
      crc_q <= crc_byte_step(crc_q, byte_data);
    end
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/rx_status_gen.sv
module rx_status_gen #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned MIN_LEN    = 64,
  parameter int unsigned MAX_LEN    = 4096,
  localparam int unsigned LEN_W     = $clog2(MAX_LEN + 2),
  localparam int unsigned ID_W      = 8 * ADDR_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frm_start,
  input  logic            byte_vld,
  input  logic [7:0]      byte_data,
  input  logic            frm_end,
  input  logic            sym_err,
  input  logic            align_err,
  input  logic            speed100,
  input  logic [ID_W-1:0] station_id,
  output logic [15:0]     stat_word,
  output logic            stat_vld
);
  import rxs_pkg::*;

  logic [LEN_W-1:0] len;
  logic             pam, bcast, mcast, crc_ok;
  logic             f_short, f_long, f_crc, f_sym;
  logic [15:0]      word_d;

  rxs_len_count #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .clr(frm_start), .inc(byte_vld), .cnt(len)
  );

  rxs_addr_class #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst(rst), .clr(frm_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_idx(len), .station_id(station_id),
    .pam(pam), .bcast(bcast), .mcast(mcast)
  );

  rxs_crc32 u_crc (
    .clk(clk), .rst(rst), .clr(frm_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .crc_ok(crc_ok)
  );

  always_comb begin
    f_short = (len < LEN_W'(MIN_LEN));
    f_long  = (len > LEN_W'(MAX_LEN));
    f_crc   = ~crc_ok;
    f_sym   = sym_err & speed100;
    word_d           = '0;
    word_d[B_MCAST]  = mcast;
    word_d[B_PAM]    = pam;
    word_d[B_BCAST]  = bcast;
    word_d[B_SYM]    = f_sym;
    word_d[B_SHORT]  = f_short;
    word_d[B_LONG]   = f_long;
    word_d[B_CRC]    = f_crc;
    word_d[B_ALIGN]  = align_err;
    word_d[B_GOOD]   = ~(f_sym | f_short | f_long | f_crc | align_err);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_word <= '0;
      stat_vld  <= 1'b0;
    end else if (frm_end) begin
      stat_word <= word_d;
      stat_vld  <= 1'b1;
    end else if (frm_start) begin
      stat_vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_status_gen_chk.sv
module rx_status_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        frm_start,
  input logic        frm_end,
  input logic        speed100,
  input logic [15:0] stat_word,
  input logic        stat_vld
);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_word[12:6] == 7'd0);

  // R4
  bc_mc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stat_word[15] && stat_word[13]));

  // R6
  short_long_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stat_word[4] && stat_word[3]));

  // R8
  sym_speed_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_end && !speed100) |=> !stat_word[5]);

  // R10
  good_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (stat_word[0] == (stat_word[5:1] == 5'd0)));

  // R11
  vld_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    frm_end |=> stat_vld);

  // R11
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_start && !frm_end) |=> !stat_vld);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_vld && !frm_start && !frm_end) |=> (stat_vld && $stable(stat_word)));

endmodule

bind rx_status_gen rx_status_gen_chk u_chk (.*);

// File: tb/rx_status_gen_tb.sv
module rx_status_gen_tb;

  localparam logic [47:0] STATION = 48'h5E4D_3C2B_1A00;
  localparam int unsigned FR_MAX  = 8200;

  logic        clk = 1'b0;
  logic        rst;
  logic        frm_start, byte_vld, frm_end, sym_err, align_err, speed100;
  logic [7:0]  byte_data;
  logic [47:0] station_id;
  logic [15:0] stat_word;
  logic        stat_vld;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] fr [0:FR_MAX-1];

  always #4 clk = ~clk;

  rx_status_gen u_dut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .frm_end(frm_end), .sym_err(sym_err),
    .align_err(align_err), .speed100(speed100), .station_id(station_id),
    .stat_word(stat_word), .stat_vld(stat_vld)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // kind: 0 station, 1 broadcast, 2 group, 3 foreign unicast, 4 near-station
  task automatic build(input int n, input int kind, input bit corrupt);
    logic [47:0] d;
    logic [31:0] fcs;
    case (kind)
      0: d = STATION;
      1: d = 48'hFFFF_FFFF_FFFF;
      2: d = 48'hFB00_005E_0001;
      3: d = 48'h6655_4433_2202;
      default: d = STATION ^ 48'h0100_0000_0000;
    endcase
    for (int i = 0; i < n; i++) fr[i] = (i < 6) ? d[8*i +: 8] : 8'((i * 13 + 7) & 255);
    if (n >= 4) begin
      fcs = ~tb_crc(n - 4);
      for (int k = 0; k < 4; k++) fr[n - 4 + k] = fcs[8*k +: 8];
      if (corrupt) fr[n - 1] = fr[n - 1] ^ 8'h01;
    end
  endtask

  task automatic run(input int n, input int kind, input bit corrupt,
                     input bit sy, input bit sp, input bit al, input bit gap);
    bit e_pa, e_bc, e_mc, e_sh, e_lg, e_cr, e_sy, e_ok;
    logic [15:0] first;
    build(n, kind, corrupt);
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    chk("R11 vld low after start", {31'b0, stat_vld}, 32'd0);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = fr[i];
      @(negedge clk);
      if (gap) begin
        byte_vld = 1'b0; byte_data = 8'hFF;
        @(negedge clk);
      end
    end
    byte_vld = 1'b0;
    frm_end = 1'b1; sym_err = sy; speed100 = sp; align_err = al;
    @(negedge clk);
    frm_end = 1'b0; sym_err = 1'b0; align_err = 1'b0;
    e_pa = (n >= 6) && ({fr[5], fr[4], fr[3], fr[2], fr[1], fr[0]} == STATION);
    e_bc = (n >= 6) && ({fr[5], fr[4], fr[3], fr[2], fr[1], fr[0]} == 48'hFFFF_FFFF_FFFF);
    e_mc = (n >= 6) && fr[0][0] && !e_bc;
    e_sh = (n < 64);
    e_lg = (n > 4096);
    e_cr = (tb_crc(n) != 32'hDEBB20E3);
    e_sy = sy && sp;
    e_ok = !(e_sh || e_lg || e_cr || e_sy || al);
    chk("R11 vld after end", {31'b0, stat_vld}, 32'd1);
    chk("R1 reserved", {25'b0, stat_word[12:6]}, 32'd0);
    chk("R2 station match", {31'b0, stat_word[14]}, {31'b0, e_pa});
    chk("R3 broadcast", {31'b0, stat_word[13]}, {31'b0, e_bc});
    chk("R4 group", {31'b0, stat_word[15]}, {31'b0, e_mc});
    chk("R5 short", {31'b0, stat_word[4]}, {31'b0, e_sh});
    chk("R6 oversize", {31'b0, stat_word[3]}, {31'b0, e_lg});
    chk("R7 crc", {31'b0, stat_word[2]}, {31'b0, e_cr});
    chk("R8 symbol", {31'b0, stat_word[5]}, {31'b0, e_sy});
    chk("R9 align", {31'b0, stat_word[1]}, {31'b0, al});
    chk("R10 good", {31'b0, stat_word[0]}, {31'b0, e_ok});
    first = stat_word;
    repeat (3) @(negedge clk);
    chk("R11 held", {15'b0, stat_vld, stat_word}, {15'b0, 1'b1, first});
  endtask

  initial begin
    rst = 1'b1; frm_start = 1'b0; byte_vld = 1'b0; byte_data = 8'h00;
    frm_end = 1'b0; sym_err = 1'b0; align_err = 1'b0; speed100 = 1'b1;
    station_id = STATION;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12 reset word", {16'b0, stat_word}, 32'd0);
    chk("R12 reset vld", {31'b0, stat_vld}, 32'd0);
    // length sweep across the short edge and address-width edge
    for (int n = 0; n <= 70; n++) run(n, n % 5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // corrupted check sequence
    for (int k = 0; k < 5; k++) run(64 + k, k, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // symbol error gated by speed, alignment error
    run(80, 0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run(80, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run(80, 2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run(80, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    // idle gaps between bytes
    run(66, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    run(63, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    // oversize edge and saturation
    for (int n = 4095; n <= 4098; n++) run(n, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run(8195, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule